// File: doc/BRIEF.md
# Address Bus Parity and Hold Unit

This unit sits on the address side of a 32-bit processor's bus interface. When the core starts a bus cycle it registers the physical address and drives it onto the external address lines. It drives an even-parity bit with it and pulses the active-low address strobe. An active-low wrap control can force address bit 20 to zero, so that accesses wrap at the 1 Mbyte boundary. The same masked address is presented to the internal cache lookup. An external agent can take the address bus away with a hold request. The address and parity drivers then switch off one clock later, and the rest of the unit keeps working.

For snoops, an external agent drives an inquire address on bits 31..5 and a parity bit, and marks them with an active-low external-address strobe. The unit checks even parity over that address and bit. It reports a mismatch as a one-clock low pulse on an active-low check output, two clocks after the strobe is sampled. Tristate pads appear as separate output-enable signals. A dual-processor configuration input is captured during reset. In dual mode the wrap control is ignored.

Top module: `addr_par_hold_unit`

## Requirements
- R1: While reset is held and at the first clock after it, `addr_oe` and `par_oe` are 0, `ads_n` is 1 and `pchk_n` is 1.
- R2: With `a20_mask_n` low and the unit not in dual mode, bit 20 of `lookup_addr` is 0 at once. Bit 20 of the address driven for a cycle started in that clock is also 0. All other bits pass unchanged.
- R3: `dual_cfg` is captured on every clock edge during reset and held afterwards. In dual mode `a20_mask_n` has no effect on either address. A later change of `dual_cfg` changes nothing.
- R4: Whenever `par_oe` is 1, `par_out` makes the XOR of `addr_out` (bits 31..3) and `par_out` equal 0 (even parity). It is valid in the same clock as the address.
- R5: If `hold_req` is 1 at a clock edge, `addr_oe` and `par_oe` are 0 for the following clock. If `hold_req` is 0 at an edge, both are 1 for the following clock.
- R6: If `core_start` is 1 at a clock edge, `ads_n` is 0 for exactly the following clock. In that clock `addr_out` carries the masked address. The address is held until the next start, and starts are accepted while the bus is held.
- R7: If `eads_n` is 0 at edge k and the XOR of `ext_addr` (bits 31..5) and `ext_par` is 1, `pchk_n` is 0 in the clock after edge k+1.
- R8: Each detected error gives exactly one clock of `pchk_n` low. Strobes on consecutive clocks are checked independently.
- R9: A strobe with correct even parity, or bad parity while `eads_n` is 1, leaves `pchk_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dual_cfg | input | 1 | Dual-processor configuration, captured during reset |
| core_addr | input | 29 | Core physical address, bits 31..3 |
| core_start | input | 1 | Bus cycle start from the core |
| a20_mask_n | input | 1 | Bit 20 wrap control, active low |
| hold_req | input | 1 | External address hold request |
| lookup_addr | output | 29 | Masked address for the cache lookup, bits 31..3 |
| addr_out | output | 29 | Driven address, bits 31..3 |
| addr_oe | output | 1 | Output enable of the address pads |
| par_out | output | 1 | Even parity of the driven address |
| par_oe | output | 1 | Output enable of the parity pad |
| ads_n | output | 1 | Address strobe, active low |
| ext_addr | input | 27 | Inquire address, bits 31..5 |
| ext_par | input | 1 | Inquire parity bit |
| eads_n | input | 1 | External-address strobe, active low |
| pchk_n | output | 1 | Inquire parity error, active low |

## Verification
The drive path is tested with a set of addresses that have bit 20 set or clear, all ones, all zeros and mixed patterns, each with the wrap control on and off. This shows whether the mask touches only bit 20 and whether parity follows the masked address and not the raw one. Dual mode is tested with the wrap control asserted and the configuration input changed after reset, which shows that the configuration really is latched. The inquire checker gets isolated good and bad strobes, a bad parity bit with no strobe, and strobes on consecutive clocks mixing errors and clean addresses. This separates the exact latency, the one-clock pulse width and the independence of the pipeline stages. Hold is applied while a cycle starts, which shows that only the pad enables react.

// File: rtl/addr_bus_pkg.sv
package addr_bus_pkg;

  // Parity fold of a zero-padded vector: 1 when the number of ones is odd.
  function automatic logic odd_ones(input logic [63:0] v);
    return ^v;
  endfunction

  // Clear bit `pos` of `v` when `en` is set.
  function automatic logic [63:0] drop_bit(input logic [63:0] v, input int unsigned pos,
                                           input logic en);
    logic [63:0] r;
    r = v;
    if (en) r[pos] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/addr_drive.sv
module addr_drive
  import addr_bus_pkg::*;
#(
  parameter int unsigned AHI      = 31,
  parameter int unsigned ALO      = 3,
  parameter int unsigned WRAP_BIT = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dual_mode,
  input  logic [AHI-ALO:0]     core_addr,
  input  logic                 core_start,
  input  logic                 a20_mask_n,
  input  logic                 hold_req,
  output logic [AHI-ALO:0]     lookup_addr,
  output logic [AHI-ALO:0]     addr_out,
  output logic                 par_out,
  output logic                 addr_oe,
  output logic                 par_oe,
  output logic                 ads_n
);
  localparam int unsigned AW = AHI - ALO + 1;

  logic          wrap_active;
  logic [63:0]   wide_addr;
  logic [63:0]   masked_wide;
  logic          next_par;
  logic [AW-1:0] addr_q;
  logic          par_q;
  logic          ads_q;
  logic          oe_q;

  assign wrap_active = !a20_mask_n && !dual_mode;
  assign wide_addr   = 64'(core_addr) << ALO;
  assign masked_wide = drop_bit(wide_addr, WRAP_BIT, wrap_active);
  assign lookup_addr = masked_wide[AHI:ALO];
  assign next_par    = odd_ones(64'(lookup_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      par_q  <= 1'b0;
      ads_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      if (core_start) begin
        addr_q <= lookup_addr;
        par_q  <= next_par;
      end
      ads_q <= !core_start;
      oe_q  <= !hold_req;
    end
  end

  assign addr_out = addr_q;
  assign par_out  = par_q;
  assign addr_oe  = oe_q;
  assign par_oe   = oe_q;
  assign ads_n    = ads_q;

  // R2
  wrap_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_active |-> !lookup_addr[WRAP_BIT-ALO]);
  // R4
  even_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (odd_ones(64'(addr_out)) == par_out));
  // R5
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |=> (!addr_oe && !par_oe));
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !ads_n);
endmodule

// File: rtl/inq_par_chk.sv
module inq_par_chk
  import addr_bus_pkg::*;
#(
  parameter int unsigned AHI = 31,
  parameter int unsigned ILO = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AHI-ILO:0] ext_addr,
  input  logic             ext_par,
  input  logic             eads_n,
  output logic             pchk_n
);
  logic bad_now;
  logic stage1_err;
  logic pchk_q;

  assign bad_now = !eads_n && (odd_ones(64'(ext_addr)) ^ ext_par);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_err <= 1'b0;
      pchk_q     <= 1'b1;
    end else begin
      stage1_err <= bad_now;
      pchk_q     <= !stage1_err;
    end
  end

  assign pchk_n = pchk_q;

  // R7
  err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_now |=> stage1_err);
  // R7
  err_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage1_err |=> !pchk_n);
  // R8
  one_clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pchk_n && !stage1_err) |=> pchk_n);
endmodule

// File: rtl/addr_par_hold_unit.sv
module addr_par_hold_unit #(
  parameter int unsigned AHI      = 31,
  parameter int unsigned ALO      = 3,
  parameter int unsigned ILO      = 5,
  parameter int unsigned WRAP_BIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_cfg,
  input  logic [AHI-ALO:0] core_addr,
  input  logic             core_start,
  input  logic             a20_mask_n,
  input  logic             hold_req,
  output logic [AHI-ALO:0] lookup_addr,
  output logic [AHI-ALO:0] addr_out,
  output logic             addr_oe,
  output logic             par_out,
  output logic             par_oe,
  output logic             ads_n,
  input  logic [AHI-ILO:0] ext_addr,
  input  logic             ext_par,
  input  logic             eads_n,
  output logic             pchk_n
);
  logic dual_q;

  always_ff @(posedge clk) begin
    if (!rst_n) dual_q <= dual_cfg;
  end

  addr_drive #(.AHI(AHI), .ALO(ALO), .WRAP_BIT(WRAP_BIT)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .dual_mode  (dual_q),
    .core_addr  (core_addr),
    .core_start (core_start),
    .a20_mask_n (a20_mask_n),
    .hold_req   (hold_req),
    .lookup_addr(lookup_addr),
    .addr_out   (addr_out),
    .par_out    (par_out),
    .addr_oe    (addr_oe),
    .par_oe     (par_oe),
    .ads_n      (ads_n)
  );

  inq_par_chk #(.AHI(AHI), .ILO(ILO)) u_inq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_addr(ext_addr),
    .ext_par (ext_par),
    .eads_n  (eads_n),
    .pchk_n  (pchk_n)
  );

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(dual_q));
endmodule

// File: tb/addr_par_hold_unit_tb.sv
module addr_par_hold_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dual_cfg = 1'b0;
  logic [28:0] core_addr = '0;
  logic        core_start = 1'b0;
  logic        a20_mask_n = 1'b1;
  logic        hold_req = 1'b0;
  logic [28:0] lookup_addr, addr_out;
  logic        addr_oe, par_out, par_oe, ads_n;
  logic [26:0] ext_addr = '0;
  logic        ext_par = 1'b0;
  logic        eads_n = 1'b1;
  logic        pchk_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  addr_par_hold_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dual_cfg(dual_cfg), .core_addr(core_addr),
    .core_start(core_start), .a20_mask_n(a20_mask_n), .hold_req(hold_req),
    .lookup_addr(lookup_addr), .addr_out(addr_out), .addr_oe(addr_oe),
    .par_out(par_out), .par_oe(par_oe), .ads_n(ads_n), .ext_addr(ext_addr),
    .ext_par(ext_par), .eads_n(eads_n), .pchk_n(pchk_n)
  );

  // {byte address, wrap control}
  localparam logic [32:0] DRV_VEC [8] = '{
    {32'h0010_0000, 1'b0}, {32'h0010_0000, 1'b1},
    {32'hFFFF_FFF8, 1'b0}, {32'hFFFF_FFF8, 1'b1},
    {32'h1234_5670, 1'b0}, {32'h8000_0008, 1'b0},
    {32'h0000_0000, 1'b1}, {32'hA5A5_A5A0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic inquire(input logic [26:0] a, input logic bad);
    ext_addr = a;
    ext_par  = (^a) ^ bad;
    eads_n   = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] exp_a;
    @(negedge clk);
    tick();
    // R1: during reset
    check("R1 addr_oe", 64'(addr_oe), 0);
    check("R1 par_oe", 64'(par_oe), 0);
    check("R1 ads_n", 64'(ads_n), 1);
    check("R1 pchk_n", 64'(pchk_n), 1);
    rst_n = 1'b1;
    tick();
    // R5 hold low at first edge -> enables on; R1 strobe and check idle
    check("R1 ads_n after reset", 64'(ads_n), 1);
    check("R1 pchk_n after reset", 64'(pchk_n), 1);
    check("R5 enable after release", 64'({addr_oe, par_oe}), 64'b11);

    // Table walk: R2, R4, R6
    foreach (DRV_VEC[i]) begin
      core_addr  = DRV_VEC[i][32:4];
      a20_mask_n = DRV_VEC[i][0];
      core_start = 1'b1;
      exp_a = DRV_VEC[i][32:1];
      if (!DRV_VEC[i][0]) exp_a[20] = 1'b0;
      #1;
      check("R2 lookup", 64'(lookup_addr), 64'(exp_a[31:3]));
      tick();
      core_start = 1'b0;
      check("R6 strobe", 64'(ads_n), 0);
      check("R2 driven", 64'(addr_out), 64'(exp_a[31:3]));
      check("R4 parity", 64'(par_out), 64'(^exp_a[31:3]));
      tick();
      check("R6 strobe ends", 64'(ads_n), 1);
      check("R6 address held", 64'(addr_out), 64'(exp_a[31:3]));
    end

    // R5: hold while a cycle starts
    hold_req   = 1'b1;
    core_addr  = 29'h0ABC_DEF;
    core_start = 1'b1;
    a20_mask_n = 1'b1;
    tick();
    core_start = 1'b0;
    check("R5 addr float", 64'(addr_oe), 0);
    check("R5 par float", 64'(par_oe), 0);
    check("R6 strobe under hold", 64'(ads_n), 0);
    hold_req = 1'b0;
    tick();
    check("R5 drive again", 64'({addr_oe, par_oe}), 64'b11);
    check("R4 parity after hold", 64'(par_out), 64'(^29'h0ABC_DEF));

    // R7, R8, R9: single bad strobe
    inquire(27'h155_AAAA, 1'b1);
    tick();
    eads_n = 1'b1;
    check("R7 not early", 64'(pchk_n), 1);
    tick();
    check("R7 error pulse", 64'(pchk_n), 0);
    tick();
    check("R8 one clock", 64'(pchk_n), 1);
    // R9: good strobe
    inquire(27'h7FF_FFFF, 1'b0);
    tick();
    eads_n = 1'b1;
    tick();
    check("R9 good parity", 64'(pchk_n), 1);
    // R9: bad parity without strobe
    ext_addr = 27'h000_0001;
    ext_par  = 1'b0;
    tick();
    tick();
    check("R9 no strobe", 64'(pchk_n), 1);
    tick();
    check("R9 no strobe later", 64'(pchk_n), 1);
    // R8: back-to-back bad, good, bad
    inquire(27'h000_0003, 1'b1);
    tick();
    inquire(27'h123_4567, 1'b0);
    tick();
    inquire(27'h7FF_FFFE, 1'b1);
    check("R8 first bad", 64'(pchk_n), 0);
    tick();
    eads_n = 1'b1;
    check("R8 good between", 64'(pchk_n), 1);
    tick();
    check("R8 second bad", 64'(pchk_n), 0);
    tick();
    check("R8 pulse ends", 64'(pchk_n), 1);

    // R3: dual mode latched at reset, later change ignored
    rst_n    = 1'b0;
    dual_cfg = 1'b1;
    tick();
    rst_n    = 1'b1;
    dual_cfg = 1'b0;
    tick();
    core_addr  = 29'h0002_0000 | 29'h0000_0015;
    a20_mask_n = 1'b0;
    core_start = 1'b1;
    #1;
    check("R3 lookup unmasked", 64'(lookup_addr), 64'(29'h0002_0015));
    tick();
    core_start = 1'b0;
    check("R3 driven unmasked", 64'(addr_out), 64'(29'h0002_0015));
    check("R4 parity dual", 64'(par_out), 64'(^29'h0002_0015));

    finish_run();
  end
endmodule